// File: doc/BRIEF.md
# Interrupt Acknowledge Read Bridge

This block lets a host processor acknowledge a bus interrupt with an ordinary 16-bit memory read. A small window of the host address space is reserved for this. A read at an aligned offset inside the window names an interrupt level: the offset is twice the level. The block then raises an acknowledge request toward a bus-master model, waits for that side to return the interrupter's status/ID word, and hands the word back on the host read data with a one-cycle ready pulse.

The window overlaps the short-address (16-bit) bus region, and the window wins. Every other read is only classified into one of three bus address spaces, or into none, and reported with a one-cycle hit pulse for the logic that serves those spaces. A bad offset, an odd address or a bus side that never answers ends the read with an error code and an all-ones data word. Only one acknowledge can be in flight. Host reads that arrive while it is pending are dropped.

Top module: `irq_ack_bridge`

## Requirements
- R1: After reset, `bus_req`, `host_ready`, `host_err` and `other_hit` are 0, `err_code` is 2'b00 and `bus_level` is 0.
- R2: A host read of address 0xC400_0000 + 2*N, with N from 1 to 7, raises `bus_req` with `bus_level` = N in the cycle after the read strobe. `bus_req` and `bus_level` then stay unchanged until `bus_ack` or timeout.
- R3: When `bus_ack` is sampled high while `bus_req` is high, the next cycle shows a one-cycle `host_ready` pulse with `host_rdata` = `bus_data`, `host_err` = 0 and `err_code` = 2'b00, and `bus_req` drops in that same cycle.
- R4: A read in the window 0xC400_0000..0xC400_00FF with address bit 0 set raises no request. The next cycle instead shows `host_ready` with `host_err` = 1, `err_code` = 2'b10 and `host_rdata` = 0xFFFF.
- R5: An even read in the window whose level field (bits 3:1) is 0, or whose bits 7:4 are not all 0, raises no request. The next cycle shows `host_ready` with `host_err` = 1, `err_code` = 2'b01 and `host_rdata` = 0xFFFF. An odd address reports R4's code instead.
- R6: If `bus_ack` has not come 255 cycles after `bus_req` rises, `host_ready` pulses in that cycle with `host_err` = 1, `err_code` = 2'b11 and `host_rdata` = 0xFFFF, and `bus_req` drops. An acknowledge sampled at the final edge still returns its data.
- R7: No address in the acknowledge window ever produces `other_hit`, even though its top nibble also selects the short space.
- R8: Any other read produces, in the next cycle, a one-cycle `other_hit` with `other_space`. The value of `other_space` depends on the address: 2'b01 for top nibble 0xC, 2'b10 for 0xD, and 2'b11 for top bits 2'b10. No hit and no ready occur for any other address.
- R9: A host read while an acknowledge is pending is ignored: no `other_hit`, no extra `host_ready`, and `bus_level` is unchanged.
- R10: `bus_ack` while no request is pending has no effect on `host_ready` or `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd | input | 1 | One-cycle host read strobe |
| host_addr | input | 32 | Host byte address, sampled with the strobe |
| host_rdata | output | 16 | Returned status/ID word or 0xFFFF on error |
| host_ready | output | 1 | One-cycle completion pulse for acknowledge-window reads |
| host_err | output | 1 | Error flag accompanying `host_ready` |
| err_code | output | 2 | 00 ok, 01 bad level, 10 misaligned, 11 timeout |
| other_hit | output | 1 | One-cycle pulse: read decoded to a non-acknowledge space |
| other_space | output | 2 | Space of that read: 01 short, 10 standard, 11 extended |
| bus_req | output | 1 | Acknowledge request to the bus-master model |
| bus_level | output | 3 | Interrupt level being acknowledged |
| bus_ack | input | 1 | Bus side has the status/ID word |
| bus_data | input | 16 | Status/ID word, valid with `bus_ack` |

## Verification
The accept edge is the clock edge that samples the read strobe. Error completions and space hits are due in the cycle after it. `bus_req` also rises in that cycle. A reply, meaning `bus_ack` sampled at some edge, shows on `host_ready` right after that edge. Timeout completion shows exactly 255 cycles after `bus_req` rises. The bench drives on falling edges and samples on falling edges, counting edges from the accept edge. It checks each pulse in the cycle it is due and again one cycle later. During waits and timeouts it also checks every intermediate cycle for an early or missing pulse.

// File: rtl/irq_ack_pkg.sv
// Shared types of the interrupt acknowledge read bridge.
// Assumes: codes are visible at the ports, so their values are fixed.
package irq_ack_pkg;

    // Completion status returned alongside host_ready.
    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_LEVEL = 2'b01,
        ERR_ALIGN = 2'b10,
        ERR_TMO   = 2'b11
    } ack_err_e;

    // Bus address space of a read outside the acknowledge window.
    typedef enum logic [1:0] {
        SPC_NONE  = 2'b00,
        SPC_SHORT = 2'b01,
        SPC_STD   = 2'b10,
        SPC_EXT   = 2'b11
    } bus_space_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ack_state_e;

endpackage

// File: rtl/irq_ack_decode.sv
// Address classifier for the acknowledge bridge.
// What it does: flags reads inside the acknowledge window, extracts the
// level (offset / 2) and the error causes, and assigns every other address
// to a bus space. A window hit masks the space result, which is the
// priority rule.
// Assumes: purely combinational; the caller samples it with the strobe.
module irq_ack_decode
    import irq_ack_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          LVL_W    = 3,
    parameter int          WIN_BITS = 8,
    parameter logic [31:0] ACK_BASE = 32'hC400_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              win_hit,
    output logic              misalign,
    output logic              bad_level,
    output logic [LVL_W-1:0]  level,
    output bus_space_e        space
);
    localparam int LVL_HI = LVL_W;      // level field spans bits LVL_HI:1
    localparam int PAD_LO = LVL_W + 1;  // offset bits that must be zero

    logic raw_short, raw_std, raw_ext;

    // Window match, level field and error causes.
    always_comb begin
        win_hit   = (addr[ADDR_W-1:WIN_BITS] == ACK_BASE[ADDR_W-1:WIN_BITS]);
        misalign  = addr[0];
        level     = addr[LVL_HI:1];
        bad_level = (addr[WIN_BITS-1:PAD_LO] != '0) || (addr[LVL_HI:1] == '0);
    end

    // Raw space matches before the window takes priority.
    always_comb begin
        raw_short = (addr[ADDR_W-1:ADDR_W-4] == 4'hC);
        raw_std   = (addr[ADDR_W-1:ADDR_W-4] == 4'hD);
        raw_ext   = (addr[ADDR_W-1:ADDR_W-2] == 2'b10);
    end

    // Space selection; a window hit overrides all of them.
    always_comb begin
        if (win_hit)        space = SPC_NONE;
        else if (raw_short) space = SPC_SHORT;
        else if (raw_std)   space = SPC_STD;
        else if (raw_ext)   space = SPC_EXT;
        else                space = SPC_NONE;
    end

endmodule

// File: rtl/irq_ack_timer.sv
// Reply timeout counter for the acknowledge bridge.
// What it does: counts the cycles the controller spends waiting. It raises
// expire during the wait cycle whose closing edge is the LIMIT-th edge.
// Assumes: run stays high for the whole wait and drops for at least one
// cycle between waits.
module irq_ack_timer #(
    parameter int LIMIT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Count wait cycles; clear whenever not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // Expiry during the wait cycle that closes the window.
    always_comb expire = run && (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);  // R6
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);  // R6

endmodule

// File: rtl/irq_ack_bridge.sv
// Interrupt acknowledge read bridge (top).
// What it does: turns a host read in the acknowledge window into a bus
// acknowledge request for level offset/2, returns the status/ID word, and
// reports errors. Reads elsewhere are classified and pulsed on other_hit.
// Assumes: host_rd is a one-cycle strobe; only one acknowledge is in flight,
// and strobes during a wait are dropped.
module irq_ack_bridge
    import irq_ack_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 16,
    parameter int          LVL_W     = 3,
    parameter int          WIN_BITS  = 8,
    parameter logic [31:0] ACK_BASE  = 32'hC400_0000,
    parameter int          TMO_LIMIT = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              host_err,
    output logic [1:0]        err_code,
    output logic              other_hit,
    output logic [1:0]        other_space,
    output logic              bus_req,
    output logic [LVL_W-1:0]  bus_level,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_data
);
    localparam logic [DATA_W-1:0] ERR_WORD = '1;

    ack_state_e       state;
    logic             win_hit, misalign, bad_level, tmo_expire;
    logic [LVL_W-1:0] dec_level;
    bus_space_e       dec_space;
    logic             accept;

    irq_ack_decode #(
        .ADDR_W  (ADDR_W),
        .LVL_W   (LVL_W),
        .WIN_BITS(WIN_BITS),
        .ACK_BASE(ACK_BASE)
    ) u_decode (
        .addr     (host_addr),
        .win_hit  (win_hit),
        .misalign (misalign),
        .bad_level(bad_level),
        .level    (dec_level),
        .space    (dec_space)
    );

    irq_ack_timer #(
        .LIMIT(TMO_LIMIT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAIT),
        .expire(tmo_expire)
    );

    // A strobe is taken only while idle.
    always_comb accept = host_rd && (state == ST_IDLE);

    // Controller: accept, wait for the reply or timeout, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bus_req     <= 1'b0;
            bus_level   <= '0;
            host_ready  <= 1'b0;
            host_err    <= 1'b0;
            err_code    <= ERR_NONE;
            host_rdata  <= '0;
            other_hit   <= 1'b0;
            other_space <= SPC_NONE;
        end else begin
            host_ready <= 1'b0;
            other_hit  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept && win_hit) begin
                        if (misalign || bad_level) begin
                            host_ready <= 1'b1;
                            host_err   <= 1'b1;
                            err_code   <= misalign ? ERR_ALIGN : ERR_LEVEL;
                            host_rdata <= ERR_WORD;
                        end else begin
                            bus_req   <= 1'b1;
                            bus_level <= dec_level;
                            state     <= ST_WAIT;
                        end
                    end else if (accept && dec_space != SPC_NONE) begin
                        other_hit   <= 1'b1;
                        other_space <= dec_space;
                    end
                end
                ST_WAIT: begin
                    if (bus_ack) begin
                        bus_req    <= 1'b0;
                        host_ready <= 1'b1;
                        host_err   <= 1'b0;
                        err_code   <= ERR_NONE;
                        host_rdata <= bus_data;
                        state      <= ST_IDLE;
                    end else if (tmo_expire) begin
                        bus_req    <= 1'b0;
                        host_ready <= 1'b1;
                        host_err   <= 1'b1;
                        err_code   <= ERR_TMO;
                        host_rdata <= ERR_WORD;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !tmo_expire |=> bus_req && $stable(bus_level));  // R2
    AST_LEVEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_level != '0);  // R2
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);  // R3
    AST_OK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready && !host_err |-> $past(bus_req) && !bus_req);  // R3
    AST_ERR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready && host_err |-> host_rdata == ERR_WORD);  // R6
    AST_HIT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        other_hit |-> other_space != SPC_NONE && !host_ready);  // R8
    AST_WAIT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !other_hit);  // R9

endmodule

// File: tb/test_irq_ack_bridge.sv
module test_irq_ack_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_addr = '0;
    logic [15:0] host_rdata;
    logic        host_ready, host_err, other_hit, bus_req, bus_ack = 1'b0;
    logic [1:0]  err_code, other_space;
    logic [2:0]  bus_level;
    logic [15:0] bus_data = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    irq_ack_bridge i_irq_ack_bridge (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
        .host_rdata(host_rdata), .host_ready(host_ready), .host_err(host_err),
        .err_code(err_code), .other_hit(other_hit), .other_space(other_space),
        .bus_req(bus_req), .bus_level(bus_level), .bus_ack(bus_ack),
        .bus_data(bus_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // 0 none, 1 short, 2 standard, 3 extended, 4 ack ok, 5 misaligned, 6 bad level
    function automatic int classify(input logic [31:0] a);
        if (a[31:8] == 24'hC40000) begin
            if (a[0]) return 5;
            if (a[7:4] != 4'h0 || a[3:1] == 3'd0) return 6;
            return 4;
        end
        if (a[31:28] == 4'hC) return 1;
        if (a[31:28] == 4'hD) return 2;
        if (a[31:30] == 2'b10) return 3;
        return 0;
    endfunction

    // Strobe one read; the next falling edge shows the accept-edge results.
    task automatic strobe(input logic [31:0] a);
        @(negedge clk); host_rd = 1'b1; host_addr = a;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input int dly, input logic [15:0] d);
        int k;
        bit held;
        k = classify(a);
        strobe(a);
        if (k == 4) begin
            chk(bus_req && bus_level == a[3:1] && !host_ready, "R2", {28'h0, bus_level}, {28'h0, a[3:1]});
            chk(!other_hit, "R7", {31'h0, other_hit}, 32'h0);
            held = 1;
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                if (!bus_req || host_ready || bus_level != a[3:1]) held = 0;
            end
            chk(held, "R2", {31'h0, held}, 32'h1);
            bus_ack = 1'b1; bus_data = d;
            @(negedge clk); bus_ack = 1'b0;
            chk(host_ready && !host_err && err_code == 2'b00 && host_rdata == d && !bus_req,
                "R3", {host_ready, host_err, err_code, 12'h0, host_rdata}, {4'b1000, 12'h0, d});
            @(negedge clk);
            chk(!host_ready, "R3", {31'h0, host_ready}, 32'h0);
        end else if (k == 5 || k == 6) begin
            chk(host_ready && host_err && !bus_req && host_rdata == 16'hFFFF &&
                err_code == (k == 5 ? 2'b10 : 2'b01), k == 5 ? "R4" : "R5",
                {30'h0, err_code}, (k == 5 ? 32'd2 : 32'd1));
            chk(!other_hit, "R7", {31'h0, other_hit}, 32'h0);
            @(negedge clk);
            chk(!host_ready, "R4", {31'h0, host_ready}, 32'h0);
        end else begin
            chk(other_hit == (k != 0) && (k == 0 || other_space == k[1:0]) &&
                !host_ready && !bus_req, "R8", {30'h0, other_space}, k);
            @(negedge clk);
            chk(!other_hit, "R8", {31'h0, other_hit}, 32'h0);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit quiet;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!bus_req && !host_ready && !host_err && !other_hit && err_code == 2'b00 &&
            bus_level == 3'd0, "R1", {bus_req, host_ready, host_err, other_hit}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: every valid level, error offsets, spaces, priority
        for (int lv = 1; lv < 8; lv++) access(32'hC400_0000 + 2 * lv, lv, 16'h1000 + 16'(lv));
        access(32'hC400_0000, 0, 16'h0);     // R5 level 0
        access(32'hC400_0010, 0, 16'h0);     // R5 offset above 14
        access(32'hC400_000F, 0, 16'h0);     // R4 odd offset 15
        access(32'hC400_0003, 0, 16'h0);     // R4 odd
        access(32'hC400_0100, 0, 16'h0);     // R8 short space, just past window
        access(32'hD123_4568, 0, 16'h0);     // R8 standard
        access(32'h8000_0000, 0, 16'h0);     // R8 extended
        access(32'h1234_0000, 0, 16'h0);     // R8 none

        // R10: stray bus_ack while idle
        bus_ack = 1'b1; bus_data = 16'hBEEF;
        @(negedge clk); bus_ack = 1'b0;
        chk(!host_ready && !bus_req, "R10", {host_ready, bus_req}, 32'h0);
        @(negedge clk);
        chk(!host_ready, "R10", {31'h0, host_ready}, 32'h0);

        // R9: strobes while waiting are dropped
        strobe(32'hC400_000A);
        @(negedge clk); host_rd = 1'b1; host_addr = 32'hD000_0000;
        @(negedge clk); host_addr = 32'hC400_0002;
        @(negedge clk); host_rd = 1'b0;
        quiet = 1;
        for (int i = 0; i < 3; i++) begin
            if (other_hit || host_ready || bus_level != 3'd5 || !bus_req) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R9", {31'h0, quiet}, 32'h1);
        bus_ack = 1'b1; bus_data = 16'h5A5A;
        @(negedge clk); bus_ack = 1'b0;
        chk(host_ready && host_rdata == 16'h5A5A, "R9", {16'h0, host_rdata}, 32'h5A5A);
        @(negedge clk);
        chk(!host_ready && !other_hit, "R9", {host_ready, other_hit}, 32'h0);

        // R6: timeout after 255 cycles
        strobe(32'hC400_0006);
        quiet = 1;
        for (int i = 0; i < 254; i++) begin
            @(negedge clk);
            if (host_ready) quiet = 0;
        end
        chk(quiet, "R6", {31'h0, quiet}, 32'h1);
        @(negedge clk);
        chk(host_ready && host_err && err_code == 2'b11 && host_rdata == 16'hFFFF && !bus_req,
            "R6", {30'h0, err_code}, 32'd3);
        @(negedge clk);

        // R6: acknowledge at the final edge still wins
        access(32'hC400_000E, 254, 16'h7E57);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            int sel;
            sel = $urandom_range(0, 3);
            if (sel < 2)       a = {24'hC40000, 8'($urandom_range(0, 255))};
            else if (sel == 2) a = $urandom;
            else               a = {4'hC, 28'($urandom)};
            if (n % 4 == 0) a = {24'hC40000, 4'h0, 3'($urandom_range(1, 7)), 1'b0};
            access(a, $urandom_range(0, 20), 16'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule